// File: doc/BRIEF.md
# 4:2:2 Chroma Pair Averager

This block sits in a streaming video path and turns full-chroma YCbCr pixels into 4:2:2 pixels. Each input beat carries one pixel. Pixels along a line are grouped in pairs: the first pixel of the line is even, the next one is odd, and so on. The two pixels of a pair keep their own luma. They leave the block with one common chroma value, which is the truncated mean of their two Cb samples and of their two Cr samples.

The even pixel is held inside the block until its odd partner is accepted. Both output beats are then formed and presented in input order. Start-of-frame and end-of-line markers stay on the pixel they arrived with. A line that ends on an even pixel is malformed, and it sets a sticky error flag.

Both sides use a valid/ready handshake. A beat moves when valid and ready are high on the same rising edge. Once the output raises valid, it holds valid, data and markers unchanged until ready is seen. The input ready is low while a finished pair is still waiting to be taken downstream, so the upstream source must hold its beat during that time. Reset is synchronous and active low.

Top module: `chroma_pair_avg`

## Requirements
- R1: The pixel word has luma in bits [23:16], Cb in bits [15:8] and Cr in bits [7:0]. Every output pixel carries its own input luma unchanged.
- R2: The shared Cb of a pair is (Cb_even + Cb_odd) >> 1, computed without overflow and truncated. The shared Cr is formed the same way. For example, 255 and 254 give 254, and 0 and 1 give 0.
- R3: Both output beats of a pair carry the same chroma. The even pixel is emitted first and the odd pixel second.
- R4: The start-of-frame marker of each input pixel appears on that pixel's own output beat, including when it was on the held even pixel.
- R5: The end-of-line marker of each input pixel appears on that pixel's own output beat, normally the odd pixel that closes a line.
- R6: While output valid is high and output ready is low, output valid, data and markers stay unchanged on the next cycle.
- R7: Input ready is high exactly when no finished pair is waiting downstream. Output valid rises on the cycle after the odd pixel is accepted, and stays high until both beats of the pair have been taken.
- R8: An end-of-line marker accepted on an even pixel sets err_odd_eol one cycle later. The flag stays set until reset, and pairing continues with the next pixel as the odd partner.
- R9: Reset drops any held even pixel, so the first pixel accepted after reset is treated as even.
- R10: After reset, m_valid is 0, s_ready is 1 and err_odd_eol is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| s_valid | input | 1 | Input beat present |
| s_ready | output | 1 | Block can take an input beat |
| s_data | input | 24 | Input pixel {Y, Cb, Cr} |
| s_sof | input | 1 | Input pixel is first of a frame |
| s_eol | input | 1 | Input pixel is last of a line |
| m_valid | output | 1 | Output beat present |
| m_ready | input | 1 | Downstream takes the output beat |
| m_data | output | 24 | Output pixel {Y, shared Cb, shared Cr} |
| m_sof | output | 1 | Output pixel is first of a frame |
| m_eol | output | 1 | Output pixel is last of a line |
| err_odd_eol | output | 1 | Sticky: a line ended on an even pixel |

## Verification
The first stream keeps both handshakes always ready. It shows that the pair timing is one cycle per stage and that markers land on the right beats. Gaps on the input valid show that holding an even pixel across idle cycles keeps it paired correctly. Random output stalls test whether the data stays held and the input ready stays low while a pair waits downstream. Extreme chroma pairs (255/254, 0/1, 255/255) separate truncation from rounding and from an 8-bit overflow. A reset in the middle of a pair and a line that ends on an even pixel cover the pairing-phase cases.

// File: rtl/cpa_pkg.sv
package cpa_pkg;
  parameter int unsigned COMP_W = 8;
  localparam int unsigned PIX_W = 3 * COMP_W;

  typedef struct packed {
    logic [COMP_W-1:0] y;
    logic [COMP_W-1:0] cb;
    logic [COMP_W-1:0] cr;
  } pix_t;

  typedef struct packed {
    pix_t pix;
    logic sof;
    logic eol;
  } beat_t;

  typedef enum logic [1:0] {
    ST_EVEN  = 2'd0,
    ST_ODD   = 2'd1,
    ST_OUT_A = 2'd2,
    ST_OUT_B = 2'd3
  } phase_e;
endpackage

// File: rtl/cpa_avg.sv
module cpa_avg #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] q
);
  localparam int unsigned SW = W + 1;
  logic [SW-1:0] sum;

  always_comb begin
    sum = {1'b0, a} + {1'b0, b};
    q   = sum[SW-1:1];
  end
endmodule

// File: rtl/cpa_ctrl.sv
module cpa_ctrl
  import cpa_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic s_valid,
  input  logic s_eol,
  input  logic m_ready,
  output logic s_ready,
  output logic m_valid,
  output logic take_even,
  output logic take_odd,
  output logic sel_b,
  output logic err
);
  phase_e st, st_n;

  always_comb begin
    s_ready   = (st == ST_EVEN) || (st == ST_ODD);
    m_valid   = (st == ST_OUT_A) || (st == ST_OUT_B);
    sel_b     = (st == ST_OUT_B);
    take_even = s_valid && (st == ST_EVEN);
    take_odd  = s_valid && (st == ST_ODD);
    st_n      = st;
    case (st)
      ST_EVEN:  if (s_valid) st_n = ST_ODD;
      ST_ODD:   if (s_valid) st_n = ST_OUT_A;
      ST_OUT_A: if (m_ready) st_n = ST_OUT_B;
      ST_OUT_B: if (m_ready) st_n = ST_EVEN;
      default:  st_n = ST_EVEN;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st  <= ST_EVEN;
      err <= 1'b0;
    end else begin
      st <= st_n;
      if (take_even && s_eol) err <= 1'b1;
    end
  end

  // R8
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |=> err);

  // R7
  pair_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_odd |=> (m_valid && !s_ready && !sel_b));

  // R6
  out_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> (m_valid && (sel_b == $past(sel_b))));

  // R3
  pair_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && m_ready && !sel_b) |=> (m_valid && sel_b));
endmodule

// File: rtl/cpa_store.sv
module cpa_store
  import cpa_pkg::*;
(
  input  logic              clk,
  input  logic              take_even,
  input  logic              take_odd,
  input  beat_t             in_beat,
  input  logic [COMP_W-1:0] avg_cb,
  input  logic [COMP_W-1:0] avg_cr,
  output beat_t             even_q,
  output beat_t             out_a,
  output beat_t             out_b
);
  always_ff @(posedge clk) begin
    if (take_even) even_q <= in_beat;
    if (take_odd) begin
      out_a.pix.y  <= even_q.pix.y;
      out_a.pix.cb <= avg_cb;
      out_a.pix.cr <= avg_cr;
      out_a.sof    <= even_q.sof;
      out_a.eol    <= even_q.eol;
      out_b.pix.y  <= in_beat.pix.y;
      out_b.pix.cb <= avg_cb;
      out_b.pix.cr <= avg_cr;
      out_b.sof    <= in_beat.sof;
      out_b.eol    <= in_beat.eol;
    end
  end
endmodule

// File: rtl/chroma_pair_avg.sv
module chroma_pair_avg
  import cpa_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PIX_W-1:0] s_data,
  input  logic             s_sof,
  input  logic             s_eol,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [PIX_W-1:0] m_data,
  output logic             m_sof,
  output logic             m_eol,
  output logic             err_odd_eol
);
  localparam int unsigned NCH = 2;

  beat_t in_beat, even_q, out_a, out_b, cur;
  logic  take_even, take_odd, sel_b;
  logic [NCH-1:0][COMP_W-1:0] ch_e, ch_o, ch_avg;

  assign in_beat.pix = pix_t'(s_data);
  assign in_beat.sof = s_sof;
  assign in_beat.eol = s_eol;

  cpa_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .s_valid   (s_valid),
    .s_eol     (s_eol),
    .m_ready   (m_ready),
    .s_ready   (s_ready),
    .m_valid   (m_valid),
    .take_even (take_even),
    .take_odd  (take_odd),
    .sel_b     (sel_b),
    .err       (err_odd_eol)
  );

  assign ch_e = {even_q.pix.cb, even_q.pix.cr};
  assign ch_o = {in_beat.pix.cb, in_beat.pix.cr};

  for (genvar g = 0; g < NCH; g++) begin : g_ch
    cpa_avg #(.W(COMP_W)) u_avg (
      .a (ch_e[g]),
      .b (ch_o[g]),
      .q (ch_avg[g])
    );
  end

  cpa_store u_store (
    .clk       (clk),
    .take_even (take_even),
    .take_odd  (take_odd),
    .in_beat   (in_beat),
    .avg_cb    (ch_avg[1]),
    .avg_cr    (ch_avg[0]),
    .even_q    (even_q),
    .out_a     (out_a),
    .out_b     (out_b)
  );

  assign cur    = sel_b ? out_b : out_a;
  assign m_data = cur.pix;
  assign m_sof  = cur.sof;
  assign m_eol  = cur.eol;

  // R1
  luma_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_odd |=> (m_data[PIX_W-1 -: COMP_W] == $past(even_q.pix.y)));

  // R6
  data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_valid && !m_ready) |=> ($stable(m_data) && $stable(m_sof) && $stable(m_eol)));

  // R4
  sof_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    take_odd |=> (m_sof == $past(even_q.sof)));
endmodule

// File: tb/chroma_pair_avg_tb_top.sv
`timescale 1ns/100ps
module chroma_pair_avg_tb_top;
  localparam int PW = cpa_pkg::PIX_W;
  localparam int BW = PW + 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic s_valid = 1'b0, s_sof = 1'b0, s_eol = 1'b0, m_ready = 1'b0;
  logic [PW-1:0] s_data = '0;
  logic s_ready, m_valid, m_sof, m_eol, err_odd_eol;
  logic [PW-1:0] m_data;

  always #2.5 clk = ~clk;

  chroma_pair_avg dut_i (
    .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_ready(s_ready),
    .s_data(s_data), .s_sof(s_sof), .s_eol(s_eol), .m_valid(m_valid),
    .m_ready(m_ready), .m_data(m_data), .m_sof(m_sof), .m_eol(m_eol),
    .err_odd_eol(err_odd_eol)
  );

  int errors = 0, checks = 0, cycles = 0;
  logic [BW-1:0] in_q[$];
  logic [BW-1:0] exp_q[$];
  logic [BW-1:0] mdl_even, last_out;
  logic mdl_odd = 1'b0, mdl_err = 1'b0, took = 1'b0, hold_chk = 1'b0;
  logic [15:0] lfsr = 16'hACE1;
  int v_pct = 100, r_pct = 100;
  string tag = "R1";

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h (cycle %0d)", req, act, exp, cycles);
    end
  endtask

  function automatic logic gate(input int pct);
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return (int'(lfsr) % 100) < pct;
  endfunction

  function automatic logic [BW-1:0] mk(input logic [7:0] y, cb, cr, input logic sof, eol);
    return {y, cb, cr, sof, eol};
  endfunction

  task automatic model_accept(input logic [BW-1:0] b);
    int acb, acr;
    if (!mdl_odd) begin
      mdl_even = b;
      mdl_odd  = 1'b1;
      if (b[0]) mdl_err = 1'b1;
    end else begin
      acb = (int'(mdl_even[17:10]) + int'(b[17:10])) / 2;
      acr = (int'(mdl_even[9:2]) + int'(b[9:2])) / 2;
      exp_q.push_back({mdl_even[25:18], 8'(acb), 8'(acr), mdl_even[1:0]});
      exp_q.push_back({b[25:18], 8'(acb), 8'(acr), b[1:0]});
      mdl_odd = 1'b0;
    end
  endtask

  task automatic step();
    logic [BW-1:0] e;
    @(negedge clk);
    cycles++;
    if (rst_n) begin
      chk("R7 m_valid", 32'(m_valid), 32'(exp_q.size() > 0));
      chk("R7 s_ready", 32'(s_ready), 32'(exp_q.size() == 0));
      chk("R8 err_odd_eol", 32'(err_odd_eol), 32'(mdl_err));
      if (hold_chk) chk("R6 held beat", 32'({m_valid, m_data, m_sof, m_eol}), 32'({1'b1, last_out}));
    end
    if (!s_valid || took) begin
      if (in_q.size() > 0 && gate(v_pct)) begin
        s_valid = 1'b1;
        {s_data, s_sof, s_eol} = in_q[0];
      end else begin
        s_valid = 1'b0;
      end
    end
    m_ready = gate(r_pct);
    #1;
    took = rst_n && s_valid && s_ready;
    if (took) begin
      model_accept(in_q.pop_front());
    end
    if (rst_n && m_valid && m_ready) begin
      if (exp_q.size() == 0) begin
        chk("R7 unexpected beat", 32'(1), 32'(0));
      end else begin
        e = exp_q.pop_front();
        chk({tag, "/R1 luma"}, 32'(m_data[23:16]), 32'(e[25:18]));
        chk({tag, "/R2/R3 chroma"}, 32'(m_data[15:0]), 32'(e[17:2]));
        chk({tag, "/R4 sof"}, 32'(m_sof), 32'(e[1]));
        chk({tag, "/R5 eol"}, 32'(m_eol), 32'(e[0]));
      end
    end
    hold_chk = rst_n && m_valid && !m_ready;
    last_out = {m_data, m_sof, m_eol};
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0; s_valid = 1'b0; took = 1'b0; hold_chk = 1'b0;
    in_q.delete(); exp_q.delete(); mdl_odd = 1'b0; mdl_err = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    #1;
    chk("R10 m_valid", 32'(m_valid), 32'(0));
    chk("R10 s_ready", 32'(s_ready), 32'(1));
    chk("R10 err_odd_eol", 32'(err_odd_eol), 32'(0));
  endtask

  task automatic drain();
    int n = 0;
    while ((in_q.size() > 0 || exp_q.size() > 0 || s_valid) && n < 5000) begin
      step(); n++;
    end
    repeat (4) step();
  endtask

  task automatic add_frame(input int lines, input int w, input int seed);
    for (int l = 0; l < lines; l++)
      for (int p = 0; p < w; p++) begin
        int n = seed + l * w + p;
        in_q.push_back(mk(8'(n * 7 + 3), 8'(n * 13 + 200), 8'(n * 29 + 5),
                          (l == 0 && p == 0), (p == w - 1)));
      end
  endtask

  initial begin
    do_reset();
    tag = "R1"; v_pct = 100; r_pct = 100;
    add_frame(2, 8, 0); drain();
    tag = "R4"; v_pct = 50;
    add_frame(3, 6, 40); drain();
    tag = "R6"; v_pct = 100; r_pct = 40;
    add_frame(3, 8, 90); drain();
    tag = "R2"; v_pct = 70; r_pct = 60;
    in_q.push_back(mk(8'd10, 8'd255, 8'd254, 1'b1, 1'b0));
    in_q.push_back(mk(8'd20, 8'd254, 8'd255, 1'b0, 1'b0));
    in_q.push_back(mk(8'd30, 8'd0,   8'd1,   1'b0, 1'b0));
    in_q.push_back(mk(8'd40, 8'd1,   8'd0,   1'b0, 1'b0));
    in_q.push_back(mk(8'd255, 8'd255, 8'd0,  1'b0, 1'b0));
    in_q.push_back(mk(8'd0,  8'd255, 8'd0,   1'b0, 1'b1));
    drain();
    tag = "R9"; v_pct = 100; r_pct = 100;
    in_q.push_back(mk(8'h11, 8'h80, 8'h90, 1'b1, 1'b0));
    step(); step();
    do_reset();
    add_frame(1, 4, 7); drain();
    tag = "R8";
    in_q.push_back(mk(8'h01, 8'h10, 8'h20, 1'b1, 1'b0));
    in_q.push_back(mk(8'h02, 8'h30, 8'h40, 1'b0, 1'b0));
    in_q.push_back(mk(8'h03, 8'h50, 8'h60, 1'b0, 1'b1));
    in_q.push_back(mk(8'h04, 8'h70, 8'h80, 1'b0, 1'b0));
    drain();
    chk("R8 flag set", 32'(err_odd_eol), 32'(1));
    add_frame(1, 4, 3); drain();
    chk("R8 flag sticky", 32'(err_odd_eol), 32'(1));
    do_reset();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(5ns * 150000);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule